// File: doc/BRIEF.md
# Multi-Mode Reloadable 16-bit Timer

This block is a 16-bit timer/counter paired with a 16-bit register that holds either a reload value or a captured count. Control bits choose what it does. It can be stopped. It can auto-reload while counting up only. It can auto-reload while counting up or down, with the direction taken from an external pin. It can capture the running count on a falling edge of that pin. It can act as a rate generator that emits a one-cycle tick on each rollover. Separately from the mode, it can drive a square wave on a clock-out pin that changes level on every rollover.

The counter advances on every clock when the counter/timer select is 0. When the select is 1, it advances on each falling edge of an external count pin. Both external pins pass through a two-flop synchronizer before their edges are detected. In up/down mode, each wrap toggles an external flag, which then serves as a 17th count bit and does not raise the interrupt. In rate-generator and clock-out operation, rollovers leave the overflow flag alone. Software can write the count and the reload value through a write strobe and data port for each. Each flag has its own clear strobe.

Top module: `reload_timer16`

## Requirements
- R1: After reset, count, capture/reload value, overflow flag, external flag, irq, baudTick and clkOut are all 0.
- R2: With runEn=0 the count holds its value and no flag is set.
- R3: Up-only auto-reload (runEn=1, baudSel=0, capSel=0, dirEn=0): the count rises by 1 per step. At FFFF the next step loads the reload value and sets the overflow flag. irq = overflow flag OR external flag.
- R4: With extCntSel=0 one step occurs per clock. With extCntSel=1 one step occurs per falling edge of cntPin, seen after the two-flop synchronizer.
- R5: Up/down auto-reload (runEn=1, baudSel=0, capSel=0, dirEn=1) with trigPin low counts down. When the count equals the reload value, the next step loads FFFF, sets the overflow flag and toggles the external flag.
- R6: Up/down mode with trigPin high counts up. The step from FFFF loads the reload value, sets the overflow flag and toggles the external flag.
- R7: In up/down mode the external flag does not contribute to irq.
- R8: Capture mode (runEn=1, baudSel=0, capSel=1) with extEn=1: a falling edge on trigPin copies the count into the capture register and sets the external flag. The counter keeps running, and the step from FFFF goes to 0000 and sets the overflow flag.
- R9: In capture mode with extEn=0, a falling edge on trigPin changes neither the capture register nor the external flag.
- R10: If a capture and extClr fall in the same cycle, the external flag ends up set.
- R11: Rate-generator mode (runEn=1, baudSel=1, any capSel/dirEn) counts up, reloads at FFFF, pulses baudTick for one cycle per rollover, and never sets the overflow flag.
- R12: With runEn=1, extCntSel=0 and outEn=1, clkOut changes level on every rollover and the overflow flag is not set. This also works together with rate-generator mode.
- R13: cntWr loads cntWrData into the count, taking priority over stepping. rldWr loads rldData into the reload register, with a capture taking priority. ovfClr clears the overflow flag, with a new overflow taking priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntPin | input | 1 | External count input, asynchronous |
| trigPin | input | 1 | External trigger/direction input, asynchronous |
| runEn | input | 1 | Run control |
| capSel | input | 1 | 1 selects capture, 0 selects auto-reload |
| extCntSel | input | 1 | 1 counts cntPin falling edges, 0 counts clocks |
| extEn | input | 1 | Enables capture on trigPin falling edge |
| dirEn | input | 1 | Enables up/down counting in auto-reload |
| baudSel | input | 1 | Selects rate-generator mode |
| outEn | input | 1 | Enables clock-out toggling |
| cntWr | input | 1 | Count write strobe |
| cntWrData | input | 16 | Count write data |
| rldWr | input | 1 | Reload register write strobe |
| rldData | input | 16 | Reload register write data |
| ovfClr | input | 1 | Clears the overflow flag |
| extClr | input | 1 | Clears the external flag |
| count | output | 16 | Current count |
| capVal | output | 16 | Capture/reload register |
| ovfFlag | output | 1 | Overflow/underflow flag |
| extFlag | output | 1 | External flag |
| irq | output | 1 | Interrupt request |
| baudTick | output | 1 | One-cycle pulse per rollover in rate mode |
| clkOut | output | 1 | Clock-out square wave |

## Verification
Timer-mode steps, wraps, flags and software writes appear right after the rising edge at which they are sampled, so checks look one cycle after the stimulus. baudTick and clkOut are registered on the wrap edge itself, so they are seen in the cycle after the count passes FFFF. Pin-driven effects (direction, count edges, capture) cost two synchronizer flops plus one edge register. A trigPin fall driven between edges is acted on at the third rising edge and captures the count held just before that edge, which is the value read at the drive plus two. The bench drives and samples on falling edges and waits out these exact counts. Before it changes direction or mode, it lets the pins settle for three cycles.

// File: rtl/rt16_pkg.sv
package rt16_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_RELOAD_UP,
    MODE_RELOAD_UPDOWN,
    MODE_CAPTURE,
    MODE_BAUD
  } modeT;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic step;          // advance the counter this cycle
    logic countUp;       // direction of the step
    logic reloadOnWrap;  // up-wrap loads reload value (else zero)
    logic extToggle;     // wraps toggle the external flag
    logic suppressOvf;   // wraps do not set the overflow flag
    logic baudOn;        // emit rate ticks on wraps
    logic clkOutOn;      // toggle clock-out on wraps
    logic capture;       // copy count into capture register
    logic extIrqEn;      // external flag feeds irq
  } strobeT;

endpackage

// File: rtl/rt16_sync.sv
module rt16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rt16_ctrl.sv
module rt16_ctrl
  import rt16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cntPin,
  input  logic   trigPin,
  input  logic   runEn,
  input  logic   capSel,
  input  logic   extCntSel,
  input  logic   extEn,
  input  logic   dirEn,
  input  logic   baudSel,
  input  logic   outEn,
  output strobeT strb
);
  logic cntSync, trigSync;
  logic cntPrev, trigPrev;
  logic cntFall, trigFall;
  modeT mode;

  rt16_sync #(.STAGES(SYNC_STAGES)) u_cntSync (
    .clk(clk), .rstN(rstN), .d(cntPin), .q(cntSync));
  rt16_sync #(.STAGES(SYNC_STAGES)) u_trigSync (
    .clk(clk), .rstN(rstN), .d(trigPin), .q(trigSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntPrev  <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      cntPrev  <= cntSync;
      trigPrev <= trigSync;
    end
  end

  assign cntFall  = cntPrev & ~cntSync;
  assign trigFall = trigPrev & ~trigSync;

  always_comb begin
    if (!runEn)       mode = MODE_OFF;
    else if (baudSel) mode = MODE_BAUD;
    else if (capSel)  mode = MODE_CAPTURE;
    else if (dirEn)   mode = MODE_RELOAD_UPDOWN;
    else              mode = MODE_RELOAD_UP;
  end

  always_comb begin
    strb.step         = (mode != MODE_OFF) && (extCntSel ? cntFall : 1'b1);
    strb.countUp      = !((mode == MODE_RELOAD_UPDOWN) && !trigSync);
    strb.reloadOnWrap = (mode != MODE_CAPTURE);
    strb.extToggle    = (mode == MODE_RELOAD_UPDOWN);
    strb.baudOn       = (mode == MODE_BAUD);
    strb.clkOutOn     = runEn && !extCntSel && outEn;
    strb.suppressOvf  = strb.baudOn || strb.clkOutOn;
    strb.capture      = (mode == MODE_CAPTURE) && extEn && trigFall;
    strb.extIrqEn     = (mode != MODE_RELOAD_UPDOWN);
  end

  // R4: an external count edge needs at least two cycles, never back to back
  a_r4_no_back_to_back_edges: assert property (@(posedge clk) disable iff (!rstN)
    (extCntSel && strb.step) |=> (!strb.step || !extCntSel));

endmodule

// File: rtl/rt16_datapath.sv
module rt16_datapath
  import rt16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic             cntWr,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             rldWr,
  input  logic [WIDTH-1:0] rldData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capVal,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             irq,
  output logic             baudTick,
  output logic             clkOut
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] cnt, capReg, nextCnt;
  logic wrapUp, wrapDown, wrapEv;
  logic suppressOvf;

  assign wrapUp      = strb.step && strb.countUp && (cnt == ALL_ONES);
  assign wrapDown    = strb.step && !strb.countUp && (cnt == capReg);
  assign wrapEv      = (wrapUp || wrapDown) && !cntWr;
  assign suppressOvf = strb.suppressOvf;

  always_comb begin
    if (cntWr)             nextCnt = cntWrData;
    else if (!strb.step)   nextCnt = cnt;
    else if (strb.countUp) nextCnt = wrapUp ? (strb.reloadOnWrap ? capReg : '0)
                                            : cnt + 1'b1;
    else                   nextCnt = wrapDown ? ALL_ONES : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      capReg   <= '0;
      ovfFlag  <= 1'b0;
      extFlag  <= 1'b0;
      baudTick <= 1'b0;
      clkOut   <= 1'b0;
    end else begin
      cnt <= nextCnt;

      if (strb.capture)  capReg <= cnt;
      else if (rldWr)    capReg <= rldData;

      if (wrapEv && !suppressOvf) ovfFlag <= 1'b1;
      else if (ovfClr)            ovfFlag <= 1'b0;

      if (strb.capture)                 extFlag <= 1'b1;
      else if (wrapEv && strb.extToggle) extFlag <= ~extFlag;
      else if (extClr)                  extFlag <= 1'b0;

      baudTick <= wrapEv && strb.baudOn;

      if (!strb.clkOutOn) clkOut <= 1'b0;
      else if (wrapEv)    clkOut <= ~clkOut;
    end
  end

  assign count  = cnt;
  assign capVal = capReg;
  assign irq    = ovfFlag || (extFlag && strb.extIrqEn);

  // R5: underflow lands on all ones
  a_r5_underflow_to_ones: assert property (@(posedge clk) disable iff (!rstN)
    (wrapDown && !cntWr) |=> (cnt == ALL_ONES));
  // R3 and R6: up-wrap in reload modes takes the reload value in force before the edge
  a_r6_upwrap_reload: assert property (@(posedge clk) disable iff (!rstN)
    (wrapUp && !cntWr && strb.reloadOnWrap) |=> (cnt == $past(capReg)));
  // R8: capture stores the pre-edge count
  a_r8_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (capReg == $past(cnt)));
  // R10: capture beats a same-cycle clear
  a_r10_capture_sets_ext: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> extFlag);
  // R11, R12: overflow flag never rises while wraps are suppressed
  a_r11_no_ovf_when_suppressed: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> !$past(suppressOvf));
  // R12: clock-out only moves on a wrap or when switched off
  a_r12_clkout_moves_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> $past(wrapEv));

endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rt16_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntPin,
  input  logic             trigPin,
  input  logic             runEn,
  input  logic             capSel,
  input  logic             extCntSel,
  input  logic             extEn,
  input  logic             dirEn,
  input  logic             baudSel,
  input  logic             outEn,
  input  logic             cntWr,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             rldWr,
  input  logic [WIDTH-1:0] rldData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capVal,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             irq,
  output logic             baudTick,
  output logic             clkOut
);
  strobeT strb;

  rt16_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .trigPin(trigPin),
    .runEn(runEn), .capSel(capSel), .extCntSel(extCntSel), .extEn(extEn),
    .dirEn(dirEn), .baudSel(baudSel), .outEn(outEn), .strb(strb));

  rt16_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntWr(cntWr), .cntWrData(cntWrData), .rldWr(rldWr), .rldData(rldData),
    .ovfClr(ovfClr), .extClr(extClr),
    .count(count), .capVal(capVal), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .irq(irq), .baudTick(baudTick), .clkOut(clkOut));

  // R2: stopped counter holds
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWr) |=> $stable(count));
  // R7: in up/down mode only the overflow flag can request
  a_r7_updown_irq_from_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !baudSel && !capSel && dirEn && !ovfFlag) |-> !irq);

endmodule

// File: tb/reload_timer16_bench.sv
module reload_timer16_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntPin = 1'b1, trigPin = 1'b1;
  logic runEn = 0, capSel = 0, extCntSel = 0, extEn = 0, dirEn = 0, baudSel = 0, outEn = 0;
  logic cntWr = 0, rldWr = 0, ovfClr = 0, extClr = 0;
  logic [15:0] cntWrData = '0, rldData = '0;
  logic [15:0] count, capVal;
  logic ovfFlag, extFlag, irq, baudTick, clkOut;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  reload_timer16 u_reload_timer16 (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .trigPin(trigPin),
    .runEn(runEn), .capSel(capSel), .extCntSel(extCntSel), .extEn(extEn),
    .dirEn(dirEn), .baudSel(baudSel), .outEn(outEn),
    .cntWr(cntWr), .cntWrData(cntWrData), .rldWr(rldWr), .rldData(rldData),
    .ovfClr(ovfClr), .extClr(extClr),
    .count(count), .capVal(capVal), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .irq(irq), .baudTick(baudTick), .clkOut(clkOut));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Load count and reload register with the timer stopped, clearing both flags
  task automatic preload(input logic [15:0] c, input logic [15:0] r);
    runEn = 0;
    cntWr = 1; cntWrData = c; rldWr = 1; rldData = r; ovfClr = 1; extClr = 1;
    step(1);
    cntWr = 0; rldWr = 0; ovfClr = 0; extClr = 0;
  endtask

  task automatic test_reset();
    chk("R1", "count", count, 0);
    chk("R1", "capVal", capVal, 0);
    chk("R1", "ovfFlag", ovfFlag, 0);
    chk("R1", "extFlag", extFlag, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "baudTick", baudTick, 0);
    chk("R1", "clkOut", clkOut, 0);
  endtask

  task automatic test_up_reload();
    capSel = 0; dirEn = 0; baudSel = 0; outEn = 0; extCntSel = 0;
    preload(16'hFFFD, 16'hFFF0);
    runEn = 1;
    step(1);
    chk("R3", "count step", count, 16'hFFFE);
    chk("R4", "one step per clock", count, 16'hFFFE);
    step(2);
    chk("R3", "wrap reload", count, 16'hFFF0);
    chk("R3", "ovf set", ovfFlag, 1);
    chk("R3", "irq", irq, 1);
    chk("R3", "ext untouched", extFlag, 0);
    ovfClr = 1; step(1); ovfClr = 0;
    chk("R13", "ovfClr", ovfFlag, 0);
    chk("R13", "count after clear", count, 16'hFFF1);
  endtask

  task automatic test_updown();
    runEn = 0; capSel = 0; dirEn = 1; trigPin = 0;
    step(3);
    preload(16'h0012, 16'h0010);
    runEn = 1;
    step(1);
    chk("R5", "count down", count, 16'h0011);
    step(2);
    chk("R5", "underflow to ones", count, 16'hFFFF);
    chk("R5", "ovf set", ovfFlag, 1);
    chk("R5", "ext toggled", extFlag, 1);
    ovfClr = 1; step(1); ovfClr = 0;
    chk("R7", "ext not in irq", irq, 0);
    chk("R7", "ext still set", extFlag, 1);
    runEn = 0; trigPin = 1;
    step(3);
    cntWr = 1; cntWrData = 16'hFFFE; step(1); cntWr = 0;
    runEn = 1;
    step(1);
    chk("R6", "count up", count, 16'hFFFF);
    step(1);
    chk("R6", "wrap reload", count, 16'h0010);
    chk("R6", "ovf set", ovfFlag, 1);
    chk("R6", "ext toggled back", extFlag, 0);
  endtask

  task automatic test_capture();
    logic [15:0] c0;
    dirEn = 0; capSel = 1; extEn = 1; trigPin = 1;
    preload(16'h0100, 16'h0000);
    runEn = 1;
    step(4);
    c0 = count;
    trigPin = 0;
    step(3);
    chk("R8", "captured count", capVal, c0 + 16'd2);
    chk("R8", "ext set", extFlag, 1);
    chk("R8", "counter runs", count, c0 + 16'd3);
    chk("R8", "irq", irq, 1);
    // R9: capture disabled
    extEn = 0; trigPin = 1; step(3);
    extClr = 1; step(1); extClr = 0;
    trigPin = 0; step(4);
    chk("R9", "capVal unchanged", capVal, c0 + 16'd2);
    chk("R9", "ext unchanged", extFlag, 0);
    // R10: capture and clear in the same cycle
    extEn = 1; trigPin = 1; step(3);
    trigPin = 0; step(2);
    extClr = 1; step(1); extClr = 0;
    chk("R10", "capture wins", extFlag, 1);
    // R8: capture-mode wrap goes to zero
    trigPin = 1;
    cntWr = 1; cntWrData = 16'hFFFF; step(1); cntWr = 0;
    chk("R13", "count write over step", count, 16'hFFFF);
    step(1);
    chk("R8", "wrap to zero", count, 16'h0000);
    chk("R8", "ovf set", ovfFlag, 1);
    extEn = 0; capSel = 0;
  endtask

  task automatic test_baud();
    int ticks = 0;
    int toggles = 0;
    logic prevOut;
    baudSel = 1; outEn = 0;
    preload(16'hFFFC, 16'hFFFC);
    runEn = 1;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (baudTick) ticks++;
    end
    chk("R11", "tick count", ticks, 10);
    chk("R11", "no ovf", ovfFlag, 0);
    chk("R11", "reloaded", count, 16'hFFFC);
    chk("R11", "clkOut idle", clkOut, 0);
    // R12: clock-out alone
    baudSel = 0; outEn = 1;
    preload(16'hFFFD, 16'hFFFD);
    runEn = 1;
    prevOut = clkOut;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (clkOut !== prevOut) toggles++;
      prevOut = clkOut;
    end
    chk("R12", "toggles", toggles, 10);
    chk("R12", "no ovf", ovfFlag, 0);
    // R12: together with rate generation
    baudSel = 1; ticks = 0; toggles = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (clkOut !== prevOut) toggles++;
      if (baudTick) ticks++;
      prevOut = clkOut;
    end
    chk("R12", "toggles with baud", toggles, 10);
    chk("R12", "ticks with clkout", ticks, 10);
    chk("R12", "no ovf both", ovfFlag, 0);
    baudSel = 0; outEn = 0;
  endtask

  task automatic test_counter_and_off();
    logic [15:0] held;
    extCntSel = 1; cntPin = 1;
    preload(16'h0000, 16'h0000);
    step(3);
    runEn = 1;
    for (int i = 0; i < 5; i++) begin
      cntPin = 0; step(2);
      cntPin = 1; step(2);
    end
    step(3);
    chk("R4", "falling edges counted", count, 5);
    runEn = 0; extCntSel = 0;
    held = count;
    step(10);
    chk("R2", "count held", count, held);
    chk("R2", "no flag", ovfFlag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    test_reset();
    test_up_reload();
    test_updown();
    test_capture();
    test_baud();
    test_counter_and_off();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule